// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver

This block receives asynchronous serial frames in the 9-bit multiprocessor format. Every frame is a start bit, eight data bits sent least significant bit first, one address-marker bit, and a stop bit. A marker of 1 means the byte names a target station; a marker of 0 means the byte is payload for whichever station was last named. There is no parity bit and no parity check: the marker bit occupies the slot where parity would sit. The line is oversampled at 16 times the bit rate, and a one-cycle enable input gives the oversampling rate.

A host controls a skip mode. While it is active, payload frames are thrown away with no side effects: the buffer does not change, no error is flagged and the done flag stays low. The first address frame after that is always taken into the buffer, and it turns skip mode off by itself. When hardware station matching is enabled, an address frame that does not equal the local station number turns skip mode back on. The station therefore sees only the payload that is sent to it. A matching address leaves skip mode off, so the payload frames that follow are received.

The host reads the received byte and its marker bit from the buffer and acknowledges it with a read strobe. The strobe clears the done flag and both error flags.

Top module: `mpuart_rx`

## Requirements
- R1: A frame made of a 0 start bit, 8 data bits sent LSB first, a marker bit and a 1 stop bit is presented on `rx_data` together with its marker bit on `rx_mpbit`, and `rx_done` goes to 1.
- R2: There is no parity check. Frames with either marker value and any data value are received without error, and the received marker value is stored in `rx_mpbit`.
- R3: While `skip_active` is 1, a frame whose marker bit is 0 leaves `rx_data`, `rx_mpbit`, `rx_done`, `frame_err` and `overrun_err` unchanged, even when its stop bit is 0 or the buffer is still unread.
- R4: A frame whose marker bit is 1 is always loaded, with `rx_mpbit` set to 1. With station matching off, such a frame sets `skip_active` to 0.
- R5: When a frame is accepted while `rx_done` is still 1 and no read strobe comes in the same cycle, `overrun_err` goes to 1 and the buffer keeps its old byte. A frame that skip mode discards never raises an overrun.
- R6: With `idcmp_en` at 1, an address frame whose byte differs from `station_id` is loaded and sets `skip_active` to 1. An address frame equal to `station_id` leaves `skip_active` at 0, and the payload frames after it are loaded.
- R7: A pulse on `skip_set` sets `skip_active` to 1 in the next cycle. If an automatic clear happens in the same cycle, the set takes priority.
- R8: A stop bit sampled as 0 loads the byte and sets `frame_err` to 1. The receiver then waits for the line to return high before it looks for the next start bit.
- R9: A low pulse shorter than half a bit time is rejected as a false start and produces no frame.
- R10: A `rd_strobe` pulse clears `rx_done`, `frame_err` and `overrun_err`.
- R11: After reset, `rx_done`, `frame_err`, `overrun_err`, `rx_mpbit` and `skip_active` are 0, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idles high |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| skip_set | input | 1 | Host pulse that turns skip mode on |
| idcmp_en | input | 1 | Enables hardware station matching |
| station_id | input | 8 | Local station number |
| rd_strobe | input | 1 | Host acknowledge of the buffer |
| rx_data | output | 8 | Received byte |
| rx_mpbit | output | 1 | Marker bit of the received byte |
| rx_done | output | 1 | Buffer holds an unread frame |
| frame_err | output | 1 | Stop bit of the loaded frame was 0 |
| overrun_err | output | 1 | A frame arrived while the buffer was unread |
| skip_active | output | 1 | Skip mode is on |

## Verification
The hardest case to reach from the ports is a host set of skip mode that lands in the same cycle as the automatic clear caused by an address frame. The cycle in which the stop bit is sampled depends on the synchronizer and on the mid-bit counter. Instead of aiming at that single cycle, the bench holds `skip_set` high for the whole stop bit, so one of the asserted cycles is certain to coincide with the clear. It then checks that the address byte was still loaded and that `skip_active` ends at 1. Discarded frames are checked through the same ports: right after each skipped frame, the bench confirms that the buffer byte and all three flags still hold their previous values.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        SMP_IDLE,
        SMP_START,
        SMP_DATA,
        SMP_MPB,
        SMP_STOP,
        SMP_HOLD
    } smp_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          mp;
        logic          stop_bad;
    } frame_t;

    function automatic logic id_hit(input logic [DW-1:0] a, input logic [DW-1:0] b);
        return a == b;
    endfunction

    // Next skip state: host set dominates; an address frame re-evaluates.
    function automatic logic skip_next(input logic cur, input logic set,
                                       input logic valid, input logic mp,
                                       input logic cmp_en, input logic hit);
        if (set)
            return 1'b1;
        if (valid && mp)
            return cmp_en && !hit;
        return cur;
    endfunction

endpackage

// File: rtl/mprx_sampler.sv
module mprx_sampler
    import mprx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   rxd,
    input  logic   tick,
    output logic   frame_valid,
    output frame_t frame
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] TOPB = BW'(DW - 1);

    logic [SYNC-1:0] sync_q;
    logic            rx_s;
    smp_state_e      state;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bit_idx;
    logic [DW-1:0]   shreg;
    logic            mp_q;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC-2:0], rxd};
    end
    assign rx_s = sync_q[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SMP_IDLE;
            cnt         <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            mp_q        <= 1'b0;
            frame_valid <= 1'b0;
            frame       <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (tick) begin
                case (state)
                    SMP_IDLE: begin
                        cnt <= '0;
                        if (!rx_s)
                            state <= SMP_START;
                    end
                    SMP_START: begin
                        if (cnt == HALF) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            state   <= rx_s ? SMP_IDLE : SMP_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SMP_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[DW-1:1]};
                            if (bit_idx == TOPB)
                                state <= SMP_MPB;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SMP_MPB: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            mp_q  <= rx_s;
                            state <= SMP_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SMP_STOP: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            frame_valid    <= 1'b1;
                            frame.data     <= shreg;
                            frame.mp       <= mp_q;
                            frame.stop_bad <= !rx_s;
                            state          <= rx_s ? SMP_IDLE : SMP_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SMP_HOLD: begin
                        if (rx_s)
                            state <= SMP_IDLE;
                    end
                    default: state <= SMP_IDLE;
                endcase
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid); // R1

    AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == SMP_HOLD && !rx_s) |=> (state == SMP_HOLD)); // R8

endmodule

// File: rtl/mprx_skipctl.sv
module mprx_skipctl
    import mprx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_valid,
    input  frame_t        frame,
    input  logic          skip_set,
    input  logic          idcmp_en,
    input  logic [DW-1:0] station_id,
    output logic          skip_q,
    output logic          accept
);
    logic hit;

    assign hit    = id_hit(frame.data, station_id);
    assign accept = frame_valid && (frame.mp || !skip_q);

    always_ff @(posedge clk) begin
        if (rst)
            skip_q <= 1'b0;
        else
            skip_q <= skip_next(skip_q, skip_set, frame_valid, frame.mp, idcmp_en, hit);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        skip_set |=> skip_q); // R7

    AST_ID_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame.mp && !idcmp_en && !skip_set) |=> !skip_q); // R4

    AST_MISMATCH_RESKIP: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame.mp && idcmp_en && (frame.data != station_id)) |=> skip_q); // R6

    AST_ID_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame.mp) |-> accept); // R4

endmodule

// File: rtl/mprx_rxbuf.sv
module mprx_rxbuf
    import mprx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  frame_t        frame,
    input  logic          rd_strobe,
    output logic [DW-1:0] data_q,
    output logic          mp_q,
    output logic          done_q,
    output logic          ferr_q,
    output logic          oerr_q
);
    logic unread;

    assign unread = done_q && !rd_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mp_q   <= 1'b0;
            done_q <= 1'b0;
            ferr_q <= 1'b0;
            oerr_q <= 1'b0;
        end else begin
            if (rd_strobe) begin
                done_q <= 1'b0;
                ferr_q <= 1'b0;
                oerr_q <= 1'b0;
            end
            if (accept) begin
                if (unread) begin
                    oerr_q <= 1'b1;
                end else begin
                    data_q <= frame.data;
                    mp_q   <= frame.mp;
                    done_q <= 1'b1;
                    ferr_q <= frame.stop_bad;
                end
            end
        end
    end

    AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (accept && done_q && !rd_strobe) |=> (oerr_q && $stable(data_q))); // R5

    AST_DONE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(accept)); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !accept) |=> (!done_q && !ferr_q && !oerr_q)); // R10

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mprx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rxd,
    input  logic          baud_tick,
    input  logic          skip_set,
    input  logic          idcmp_en,
    input  logic [DW-1:0] station_id,
    input  logic          rd_strobe,
    output logic [DW-1:0] rx_data,
    output logic          rx_mpbit,
    output logic          rx_done,
    output logic          frame_err,
    output logic          overrun_err,
    output logic          skip_active
);
    logic   frame_valid;
    frame_t frame;
    logic   accept;

    mprx_sampler #(.OSR(OSR), .SYNC(SYNC)) u_sampler (
        .clk         (clk),
        .rst         (rst),
        .rxd         (rxd),
        .tick        (baud_tick),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    mprx_skipctl u_skip (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame       (frame),
        .skip_set    (skip_set),
        .idcmp_en    (idcmp_en),
        .station_id  (station_id),
        .skip_q      (skip_active),
        .accept      (accept)
    );

    mprx_rxbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .frame     (frame),
        .rd_strobe (rd_strobe),
        .data_q    (rx_data),
        .mp_q      (rx_mpbit),
        .done_q    (rx_done),
        .ferr_q    (frame_err),
        .oerr_q    (overrun_err)
    );

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && skip_active && !frame.mp && !rd_strobe) |=>
        ($stable(rx_data) && $stable(rx_done) && $stable(frame_err) &&
         $stable(overrun_err) && $stable(rx_mpbit))); // R3

endmodule

// File: tb/tb_mpuart_rx.sv
module tb_mpuart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       rxd;
    logic       baud_tick;
    logic       skip_set;
    logic       idcmp_en;
    logic [7:0] station_id;
    logic       rd_strobe;
    logic [7:0] rx_data;
    logic       rx_mpbit;
    logic       rx_done;
    logic       frame_err;
    logic       overrun_err;
    logic       skip_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct packed {
        logic [7:0] data;
        logic       mp;
        logic       ferr;
    } exp_t;
    exp_t exp_q[$];

    // reference model state
    bit         m_skip   = 0;
    bit         m_unread = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mpuart_rx dut (
        .clk         (clk),
        .rst         (rst),
        .rxd         (rxd),
        .baud_tick   (baud_tick),
        .skip_set    (skip_set),
        .idcmp_en    (idcmp_en),
        .station_id  (station_id),
        .rd_strobe   (rd_strobe),
        .rx_data     (rx_data),
        .rx_mpbit    (rx_mpbit),
        .rx_done     (rx_done),
        .frame_err   (frame_err),
        .overrun_err (overrun_err),
        .skip_active (skip_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops an expected item on every new buffer load
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst && rx_done && !prev_done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1 unexpected load", int'(rx_data), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rx_data == e.data, "R1 data", int'(rx_data), int'(e.data));
                chk(rx_mpbit == e.mp, "R2 marker", int'(rx_mpbit), int'(e.mp));
                chk(frame_err == e.ferr, "R8 frame_err", int'(frame_err), int'(e.ferr));
            end
        end
        prev_done = rx_done;
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_bit(input logic b, input int n);
        rxd = b;
        idle(n);
    endtask

    task automatic send(input logic [7:0] d, input logic mp, input bit stop_ok,
                        input bit hold_set);
        bit take;
        take = mp || !m_skip;
        if (take) begin
            if (!m_unread) begin
                exp_q.push_back({d, mp, !stop_ok});
                m_unread = 1;
            end
            if (mp)
                m_skip = idcmp_en && (d != station_id);
        end
        if (hold_set)
            m_skip = 1;
        drive_bit(1'b0, BITC);
        for (int i = 0; i < 8; i++)
            drive_bit(d[i], BITC);
        drive_bit(mp, BITC);
        if (hold_set) skip_set = 1'b1;
        drive_bit(stop_ok ? 1'b1 : 1'b0, BITC);
        skip_set = 1'b0;
        drive_bit(1'b1, 8);
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        idle(1);
        rd_strobe = 1'b0;
        m_unread  = 0;
        idle(1);
    endtask

    task automatic host_skip();
        skip_set = 1'b1;
        idle(1);
        skip_set = 1'b0;
        m_skip   = 1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; baud_tick = 1'b1; skip_set = 1'b0;
        idcmp_en = 1'b0; station_id = 8'h5A; rd_strobe = 1'b0;
        idle(5);
        rst = 1'b0;
        idle(2);
        // R11 reset state
        chk(!rx_done && !frame_err && !overrun_err, "R11 flags", {rx_done, frame_err, overrun_err}, 0);
        chk(!rx_mpbit && !skip_active && rx_data == 8'h00, "R11 buffer", int'(rx_data), 0);

        // R1 / R2 basic reception, both marker values
        send(8'hA5, 1'b0, 1, 0);
        chk(rx_done == 1'b1, "R1 done", int'(rx_done), 1);
        host_read();
        chk(!rx_done, "R10 done cleared", int'(rx_done), 0);
        send(8'h03, 1'b1, 1, 0);
        chk(rx_mpbit == 1'b1 && !frame_err, "R2 marker stored", int'(rx_mpbit), 1);
        host_read();

        // R7 host set, R3 payload dropped in skip mode
        host_skip();
        chk(skip_active == 1'b1, "R7 skip set", int'(skip_active), 1);
        send(8'h55, 1'b0, 1, 0);
        chk(!rx_done && rx_data == 8'h03, "R3 dropped data", int'(rx_data), 8'h03);
        send(8'h66, 1'b0, 0, 0);
        chk(!frame_err && !rx_done, "R3 no framing error", int'(frame_err), 0);
        // R4 address frame ends skip mode
        send(8'h01, 1'b1, 1, 0);
        chk(rx_done && rx_mpbit && !skip_active, "R4 skip cleared", int'(skip_active), 0);
        host_read();

        // R5 overrun keeps old byte
        send(8'h11, 1'b0, 1, 0);
        send(8'h22, 1'b0, 1, 0);
        chk(overrun_err == 1'b1, "R5 overrun", int'(overrun_err), 1);
        chk(rx_data == 8'h11, "R5 old byte kept", int'(rx_data), 8'h11);
        host_read();
        chk(!overrun_err && !rx_done, "R10 overrun cleared", int'(overrun_err), 0);

        // R5 no overrun for a skipped frame
        send(8'h33, 1'b0, 1, 0);
        host_skip();
        send(8'h44, 1'b0, 1, 0);
        chk(!overrun_err && rx_data == 8'h33, "R5 skipped no overrun", int'(overrun_err), 0);
        host_read();

        // R6 station matching
        idcmp_en = 1'b1;
        send(8'h07, 1'b1, 1, 0);
        chk(rx_data == 8'h07 && skip_active, "R6 mismatch reskips", int'(skip_active), 1);
        host_read();
        send(8'h68, 1'b0, 1, 0);
        chk(!rx_done, "R6 foreign payload dropped", int'(rx_done), 0);
        send(8'h5A, 1'b1, 1, 0);
        chk(!skip_active && rx_data == 8'h5A, "R6 match stays open", int'(skip_active), 0);
        host_read();
        send(8'h77, 1'b0, 1, 0);
        chk(rx_done && rx_data == 8'h77, "R6 payload accepted", int'(rx_data), 8'h77);
        host_read();
        idcmp_en = 1'b0;

        // R8 framing error, then recovery
        send(8'h99, 1'b0, 0, 0);
        chk(frame_err && rx_data == 8'h99, "R8 frame_err set", int'(frame_err), 1);
        host_read();
        chk(!frame_err, "R10 frame_err cleared", int'(frame_err), 0);
        send(8'h12, 1'b0, 1, 0);
        chk(rx_data == 8'h12 && !frame_err, "R8 recovery", int'(rx_data), 8'h12);
        host_read();

        // R9 short glitch rejected
        drive_bit(1'b0, 5);
        drive_bit(1'b1, 3 * BITC);
        chk(!rx_done && rx_data == 8'h12, "R9 glitch ignored", int'(rx_done), 0);
        send(8'hC3, 1'b0, 1, 0);
        chk(rx_data == 8'hC3, "R9 next frame ok", int'(rx_data), 8'hC3);
        host_read();

        // R7 set wins over automatic clear
        host_skip();
        send(8'h40, 1'b1, 1, 1);
        chk(rx_data == 8'h40 && rx_done, "R7 address still loaded", int'(rx_data), 8'h40);
        chk(skip_active == 1'b1, "R7 set beats clear", int'(skip_active), 1);
        host_read();

        idle(4);
        chk(exp_q.size() == 0, "R1 all loads seen", exp_q.size(), 0);
        finish_run();
    end

endmodule